// File: doc/BRIEF.md
# FIFO Trigger Level Selector

This block decides when a UART's transmit and receive FIFOs have reached the level at which an interrupt or DMA request should be raised. It holds one 8-bit level register with two 4-bit fields, one for each direction. A nonzero field gives a programmable level in steps of four. A zero field hands that direction back to a fixed level, which a 2-bit select from the FIFO control register picks.

The receive flag compares the selected level with the number of characters held in the receive FIFO. The transmit flag compares its level with the number of free spaces in the transmit FIFO, not with the number of bytes stored. Writes to the level register are accepted only while both the enhanced-feature enable and the modem-control mode bit are high. The FIFOs, the interrupt priority logic and the DMA handshake sit outside this block.

Top module: `fifo_trig_sel`

## Requirements
- R1: After reset the level register holds zero, so both directions use their fallback levels.
- R2: A write with `wr_en` high changes the register only when `enh_en` and `mode_en` are both 1. Any other write leaves the flags as they were.
- R3: The low field, `wr_data[3:0]`, sets the transmit level to 4 × field. `tx_trig` is 1 exactly when `tx_free` is greater than or equal to that level.
- R4: The high field, `wr_data[7:4]`, sets the receive level to 4 × field. `rx_trig` is 1 exactly when `rx_count` is greater than or equal to that level.
- R5: A zero field selects the fallback for its own direction only. The other direction keeps its programmed level.
- R6: The receive fallback for `fcr_rx_sel` is 0→8, 1→16, 2→56, 3→60.
- R7: The transmit fallback for `fcr_tx_sel` is 0→8, 1→16, 2→32, 3→56.
- R8: An accepted write is visible on the flags from the clock edge that captures it, and not before.
- R9: A field value of 15 gives a level of 60, a field value of 1 gives 4, and a count of 64 (a full FIFO) asserts the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the level register |
| wr_data | input | 8 | Write data: [7:4] receive field, [3:0] transmit field |
| enh_en | input | 1 | Enhanced-feature enable, write gate |
| mode_en | input | 1 | Modem-control mode bit, write gate |
| fcr_tx_sel | input | 2 | Transmit fallback level select |
| fcr_rx_sel | input | 2 | Receive fallback level select |
| tx_free | input | 7 | Free spaces in the transmit FIFO |
| rx_count | input | 7 | Characters held in the receive FIFO |
| tx_trig | output | 1 | Transmit trigger condition |
| rx_trig | output | 1 | Receive trigger condition |

## Verification
All state in this block is the 8-bit level register, and both flags are combinational functions of that register and the counts. A corrupted or wrongly gated register value therefore appears on the flags in the first cycle after the faulty edge, but only when a count lies between the correct level and the wrong one. For this reason the bench places the counts at each level minus one and at the level itself, in every mode.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } trig_dir_e;

    // Fixed receive levels selected by the FCR code
    function automatic int unsigned rx_fallback(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

    // Fixed transmit levels (free spaces) selected by the FCR code
    function automatic int unsigned tx_fallback(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 56;
        endcase
    endfunction

endpackage

// File: rtl/fifo_trig_reg.sv
module fifo_trig_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             enh_en,
    input  logic             mode_en,
    output logic [REG_W-1:0] reg_q
);

    logic wr_ok;

    assign wr_ok = wr_en && enh_en && mode_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_ok) begin
            reg_q <= wr_data;
        end
    end

endmodule

// File: rtl/fifo_trig_level.sv
module fifo_trig_level
    import fifo_trig_pkg::*;
#(
    parameter trig_dir_e DIR     = DIR_TX,
    parameter int        FIELD_W = 4,
    parameter int        STEP    = 4,
    parameter int        CNT_W   = 7
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [1:0]         fcr_sel,
    output logic [CNT_W-1:0]   level
);

    logic [CNT_W-1:0] fb_level;
    logic [CNT_W-1:0] prog_level;

    generate
        if (DIR == DIR_RX) begin : g_rx
            always_comb fb_level = CNT_W'(rx_fallback(fcr_sel));
        end else begin : g_tx
            always_comb fb_level = CNT_W'(tx_fallback(fcr_sel));
        end
    endgenerate

    assign prog_level = CNT_W'(field) * CNT_W'(STEP);
    assign level      = (field == '0) ? fb_level : prog_level;

endmodule

// File: rtl/fifo_trig_cmp.sv
module fifo_trig_cmp #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    output logic             trig
);

    assign trig = (count >= level);

endmodule

// File: rtl/fifo_trig_sel.sv
module fifo_trig_sel
    import fifo_trig_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int FIELD_W = 4,
    parameter int STEP    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2*FIELD_W-1:0]       wr_data,
    input  logic                       enh_en,
    input  logic                       mode_en,
    input  logic [1:0]                 fcr_tx_sel,
    input  logic [1:0]                 fcr_rx_sel,
    input  logic [$clog2(DEPTH+1)-1:0] tx_free,
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       tx_trig,
    output logic                       rx_trig
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int REG_W = 2 * FIELD_W;
    localparam int NDIR  = 2;

    logic [REG_W-1:0] reg_q;
    logic [1:0]       sel_a  [NDIR];
    logic [CNT_W-1:0] cnt_a  [NDIR];
    logic [CNT_W-1:0] lvl_a  [NDIR];
    logic             trig_a [NDIR];

    fifo_trig_reg #(.REG_W(REG_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .enh_en  (enh_en),
        .mode_en (mode_en),
        .reg_q   (reg_q)
    );

    // index 0: transmit (low field), index 1: receive (high field)
    assign sel_a[0] = fcr_tx_sel;
    assign sel_a[1] = fcr_rx_sel;
    assign cnt_a[0] = tx_free;
    assign cnt_a[1] = rx_count;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            fifo_trig_level #(
                .DIR     ((d == 1) ? DIR_RX : DIR_TX),
                .FIELD_W (FIELD_W),
                .STEP    (STEP),
                .CNT_W   (CNT_W)
            ) u_level (
                .field   (reg_q[d*FIELD_W +: FIELD_W]),
                .fcr_sel (sel_a[d]),
                .level   (lvl_a[d])
            );

            fifo_trig_cmp #(.CNT_W(CNT_W)) u_cmp (
                .count (cnt_a[d]),
                .level (lvl_a[d]),
                .trig  (trig_a[d])
            );
        end
    endgenerate

    assign tx_trig = trig_a[0];
    assign rx_trig = trig_a[1];

endmodule

// File: rtl/fifo_trig_sel_chk.sv
module fifo_trig_sel_chk #(
    parameter int DEPTH   = 64,
    parameter int FIELD_W = 4,
    parameter int STEP    = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [2*FIELD_W-1:0]       wr_data,
    input logic                       enh_en,
    input logic                       mode_en,
    input logic [$clog2(DEPTH+1)-1:0] tx_free,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       tx_trig,
    input logic                       rx_trig,
    input logic [2*FIELD_W-1:0]       reg_q
);

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int MAX_LVL = ((2 ** FIELD_W) - 1) * STEP;

    assert_blocked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && enh_en && mode_en) |=> $stable(reg_q));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && enh_en && mode_en) |=> (reg_q == $past(wr_data)));

    assert_rx_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= CNT_W'(MAX_LVL)) |-> rx_trig);

    assert_rx_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count < CNT_W'(STEP)) |-> !rx_trig);

    assert_tx_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free >= CNT_W'(MAX_LVL)) |-> tx_trig);

    assert_tx_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free < CNT_W'(STEP)) |-> !tx_trig);

endmodule

bind fifo_trig_sel fifo_trig_sel_chk #(
    .DEPTH   (DEPTH),
    .FIELD_W (FIELD_W),
    .STEP    (STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .enh_en   (enh_en),
    .mode_en  (mode_en),
    .tx_free  (tx_free),
    .rx_count (rx_count),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .reg_q    (reg_q)
);

// File: tb/test_fifo_trig_sel.sv
module test_fifo_trig_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       enh_en = 1'b0;
    logic       mode_en = 1'b0;
    logic [1:0] fcr_tx_sel = '0;
    logic [1:0] fcr_rx_sel = '0;
    logic [6:0] tx_free = '0;
    logic [6:0] rx_count = '0;
    logic       tx_trig;
    logic       rx_trig;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fifo_trig_sel i_fifo_trig_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .enh_en     (enh_en),
        .mode_en    (mode_en),
        .fcr_tx_sel (fcr_tx_sel),
        .fcr_rx_sel (fcr_rx_sel),
        .tx_free    (tx_free),
        .rx_count   (rx_count),
        .tx_trig    (tx_trig),
        .rx_trig    (rx_trig)
    );

    function automatic int rx_fb(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int tx_fb(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 32;
            default: return 56;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // Called just after a falling edge; applies counts and samples mid-cycle
    task automatic probe(input string req, input int rxc, input int txf,
                         input logic exp_rx, input logic exp_tx);
        rx_count = 7'(rxc);
        tx_free  = 7'(txf);
        #1;
        chk(req, $sformatf("rx_trig rx_count=%0d", rxc), rx_trig, exp_rx);
        chk(req, $sformatf("tx_trig tx_free=%0d", txf), tx_trig, exp_tx);
    endtask

    task automatic write_reg(input logic [7:0] d, input logic e, input logic m);
        @(negedge clk);
        wr_data = d; enh_en = e; mode_en = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; enh_en = 1'b0; mode_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        fcr_rx_sel = 2'd0; fcr_tx_sel = 2'd0;
        probe("R1", 7, 7, 1'b0, 1'b0);
        probe("R1", 8, 8, 1'b1, 1'b1);
    endtask

    task automatic t_fallback;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            fcr_rx_sel = 2'(s); fcr_tx_sel = 2'(s);
            probe("R6/R7", rx_fb(2'(s)) - 1, tx_fb(2'(s)) - 1, 1'b0, 1'b0);
            probe("R6/R7", rx_fb(2'(s)),     tx_fb(2'(s)),     1'b1, 1'b1);
        end
        // opposite selects to separate the two tables
        @(negedge clk);
        fcr_rx_sel = 2'd2; fcr_tx_sel = 2'd3;
        probe("R6", 55, 56, 1'b0, 1'b1);
        probe("R7", 56, 55, 1'b1, 1'b0);
    endtask

    task automatic t_gating;
        fcr_rx_sel = 2'd0; fcr_tx_sel = 2'd0;
        write_reg(8'h11, 1'b1, 1'b0);
        probe("R2", 4, 4, 1'b0, 1'b0);
        write_reg(8'h11, 1'b0, 1'b1);
        probe("R2", 4, 4, 1'b0, 1'b0);
        write_reg(8'h11, 1'b0, 1'b0);
        probe("R2", 4, 4, 1'b0, 1'b0);
        write_reg(8'h11, 1'b1, 1'b1);
        probe("R2", 4, 4, 1'b1, 1'b1);
        probe("R2", 3, 3, 1'b0, 1'b0);
    endtask

    task automatic t_timing;
        // register currently 0x11 (levels 4); write 0x22 (levels 8)
        @(negedge clk);
        wr_data = 8'h22; enh_en = 1'b1; mode_en = 1'b1; wr_en = 1'b1;
        probe("R8", 4, 4, 1'b1, 1'b1);
        @(negedge clk);
        wr_en = 1'b0; enh_en = 1'b0; mode_en = 1'b0;
        probe("R8", 4, 4, 1'b0, 1'b0);
        probe("R8", 8, 8, 1'b1, 1'b1);
    endtask

    task automatic t_program;
        write_reg(8'h3A, 1'b1, 1'b1);  // rx 12, tx 40
        probe("R4", 11, 39, 1'b0, 1'b0);
        probe("R3", 12, 40, 1'b1, 1'b1);
        probe("R3", 40, 12, 1'b1, 1'b0);
        write_reg(8'hA3, 1'b1, 1'b1);  // rx 40, tx 12
        probe("R4", 39, 11, 1'b0, 1'b0);
        probe("R4", 40, 12, 1'b1, 1'b1);
    endtask

    task automatic t_mixed;
        fcr_rx_sel = 2'd1; fcr_tx_sel = 2'd2;
        write_reg(8'h05, 1'b1, 1'b1);  // rx fallback 16, tx 20
        probe("R5", 15, 19, 1'b0, 1'b0);
        probe("R5", 16, 20, 1'b1, 1'b1);
        write_reg(8'h90, 1'b1, 1'b1);  // rx 36, tx fallback 32
        probe("R5", 35, 31, 1'b0, 1'b0);
        probe("R5", 36, 32, 1'b1, 1'b1);
    endtask

    task automatic t_extremes;
        write_reg(8'hFF, 1'b1, 1'b1);
        probe("R9", 59, 59, 1'b0, 1'b0);
        probe("R9", 60, 60, 1'b1, 1'b1);
        probe("R9", 64, 64, 1'b1, 1'b1);
        write_reg(8'h11, 1'b1, 1'b1);
        probe("R9", 3, 3, 1'b0, 1'b0);
        probe("R9", 4, 4, 1'b1, 1'b1);
        probe("R9", 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_fallback;
        t_gating;
        t_timing;
        t_program;
        t_mixed;
        t_extremes;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule